// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus (clock line plus open-drain data line) that fronts a 128-byte storage array built from flip-flops. A fast system clock samples both bus lines through synchronisers. The block recognises start and stop conditions on the bus. It answers only to a slave address byte whose upper nibble is the fixed device code and whose next three bits equal the strap inputs. It pulls the data line low through `sda_oe_o` to acknowledge and to shift out read data.

Writes reach a four-entry page buffer that is committed to the array when the stop condition arrives. A timer of `WRITE_CLKS` system clocks then models the self-timed programming cycle, and the slave ignores the bus for that whole window. Reads come from an internal word-address counter. A master loads that counter with a dummy write, then reads from it either directly or after a repeated start. It then keeps reading for as long as it acknowledges each byte. The write-protect input `wc_i` suppresses the commit.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset every array byte reads 0x00, the word-address counter is 0 and `sda_oe_o` is low.
- R2: The slave acknowledges a slave address byte only when bits 7:4 equal 4'b1010 and bits 3:1 equal `strap_i`. Bit 0 is R/W, with 1 meaning read. A mismatched byte gets no acknowledge, and the slave stays silent until the next start condition.
- R3: A byte write consists of a start, the address byte with R/W=0, a word-address byte (bits 6:0 used) and one data byte. The slave acknowledges each of these bytes. The stop that follows stores the data byte at the given address.
- R4: A write may carry any number of data bytes. Each one goes to the current page (address bits 6:2 fixed), and only bits 1:0 of the counter advance. A fifth or later byte overwrites the earlier byte at the same in-page position, so the last byte written there wins.
- R5: The array changes only at a stop condition that ends a write. Buffered write data is dropped when a new start condition arrives before the stop.
- R6: For `WRITE_CLKS` clocks after a committing stop, the slave acknowledges nothing and does not drive the data line.
- R7: When `wc_i` is high at the stop, the array is left unchanged and no write cycle starts. The data bytes are still acknowledged.
- R8: A random read consists of a dummy write that supplies the word address, then a repeated start with R/W=1. It returns data starting at that address.
- R9: During reads the counter advances over all 7 bits after each byte and rolls over from 127 to 0. Output continues while the master acknowledges.
- R10: A read that starts without a word address (current-address read) begins at the counter value that the previous read left behind.
- R11: A master no-acknowledge after a read byte ends the transfer: the slave releases the data line and waits for a new start condition.
- R12: The slave changes its data-line drive only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| strap_i | input | 3 | Address strap bits compared with slave address bits 3:1 |
| wc_i | input | 1 | Write control; high blocks the commit to the array |
| sda_oe_o | output | 1 | High pulls the data line low (open-drain enable) |

## Verification
Every bus-side result appears a few system clocks after the bus edge that causes it, because the synchroniser stages and one state register sit in the path. The bench therefore holds each bus phase for five clocks and samples the wired data line late in the clock-high phase. That sampling point is well after acknowledge and read bits settle. The array result of a write exists only after the stop and the `WRITE_CLKS` window. The bench first probes inside that window, expecting no acknowledge. It then waits the full window plus margin before reading back, and compares the data with a bench model of page wrap, counter rollover and write inhibit.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} tws_state_e;
  typedef enum logic [1:0] {K_DEV, K_ADDR, K_DATA} tws_kind_e;
  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/tws_line_mon.sv
module tws_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES:0] scl_sr, sda_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-1:0], scl_i};
      sda_sr <= {sda_sr[SYNC_STAGES-1:0], sda_i};
    end
  end

  logic scl_n, scl_p, sda_n, sda_p;
  assign scl_n = scl_sr[SYNC_STAGES-1];
  assign scl_p = scl_sr[SYNC_STAGES];
  assign sda_n = sda_sr[SYNC_STAGES-1];
  assign sda_p = sda_sr[SYNC_STAGES];

  assign sda_o      = sda_n;
  assign scl_rise_o = scl_n & ~scl_p;
  assign scl_fall_o = ~scl_n & scl_p;
  assign start_o    = scl_n & scl_p & sda_p & ~sda_n;
  assign stop_o     = scl_n & scl_p & ~sda_p & sda_n;
endmodule

// File: rtl/tws_write_timer.sv
module tws_write_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int W = $clog2(CYCLES + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (start_i)     cnt_q <= W'(CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int PAGE_W      = 2,
  parameter int WRITE_CLKS  = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wc_i,
  output logic       sda_oe_o
);
  import tws_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic sda_s, scl_rise, scl_fall, start_raw, stop_raw;
  logic wr_busy, start_ev, stop_ev, commit;

  tws_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_raw), .stop_o(stop_raw)
  );

  tws_state_e              st_q;
  tws_kind_e               kind_q;
  logic                    rw_q;
  logic [DATA_W-1:0]       sh_q;
  logic [CNT_W-1:0]        cnt_q;
  logic [ADDR_W-1:0]       addr_q;
  logic [DATA_W-1:0]       pbuf_q [PAGE];
  logic [PAGE-1:0]         pmask_q;
  logic [DATA_W-1:0]       mem_q  [DEPTH];

  assign start_ev = start_raw & ~wr_busy;
  assign stop_ev  = stop_raw & ~wr_busy;
  assign commit   = stop_ev & (|pmask_q) & ~wc_i;

  tws_write_timer #(.CYCLES(WRITE_CLKS)) u_timer (
    .clk_i, .rst_ni, .start_i(commit), .busy_o(wr_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      kind_q  <= K_DEV;
      rw_q    <= 1'b0;
      sh_q    <= '0;
      cnt_q   <= '0;
      addr_q  <= '0;
      pmask_q <= '0;
      for (int p = 0; p < PAGE; p++) pbuf_q[p] <= '0;
    end else if (wr_busy) begin
      st_q <= ST_IDLE;
    end else if (start_ev) begin
      st_q    <= ST_RX;
      kind_q  <= K_DEV;
      cnt_q   <= '0;
      pmask_q <= '0;
    end else if (stop_ev) begin
      st_q    <= ST_IDLE;
      pmask_q <= '0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise && cnt_q != CNT_W'(DATA_W)) begin
            sh_q  <= {sh_q[DATA_W-2:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_W'(DATA_W)) begin
            cnt_q <= '0;
            unique case (kind_q)
              K_DEV: begin
                if (sh_q[7:4] == DEV_CODE && sh_q[3:1] == strap_i) begin
                  rw_q <= sh_q[0];
                  st_q <= ST_ACK;
                end else begin
                  st_q <= ST_IDLE;
                end
              end
              K_ADDR: begin
                addr_q  <= sh_q[ADDR_W-1:0];
                pmask_q <= '0;
                st_q    <= ST_ACK;
              end
              default: begin
                pbuf_q[addr_q[PAGE_W-1:0]]  <= sh_q;
                pmask_q[addr_q[PAGE_W-1:0]] <= 1'b1;
                addr_q[PAGE_W-1:0]          <= addr_q[PAGE_W-1:0] + 1'b1;
                st_q                        <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (kind_q == K_DEV && rw_q) begin
              sh_q   <= mem_q[addr_q];
              addr_q <= addr_q + 1'b1;
              st_q   <= ST_TX;
            end else begin
              kind_q <= (kind_q == K_DEV) ? K_ADDR : K_DATA;
              st_q   <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_W'(DATA_W - 1)) begin
              st_q <= ST_MACK;
            end else begin
              sh_q  <= {sh_q[DATA_W-2:0], 1'b1};
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise && sda_s) begin
            st_q <= ST_IDLE;  // master NACK ends the read
          end else if (scl_fall) begin
            sh_q   <= mem_q[addr_q];
            addr_q <= addr_q + 1'b1;
            cnt_q  <= '0;
            st_q   <= ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (commit) begin
      for (int p = 0; p < PAGE; p++)
        if (pmask_q[p]) mem_q[{addr_q[ADDR_W-1:PAGE_W], PAGE_W'(p)}] <= pbuf_q[p];
    end
  end

  assign sda_oe_o = (st_q == ST_ACK) | ((st_q == ST_TX) & ~sh_q[DATA_W-1]);

  logic [DEPTH*DATA_W-1:0] mem_flat;
  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign mem_flat[g*DATA_W +: DATA_W] = mem_q[g];
  end
endmodule

// File: rtl/tws_sva.sv
module tws_sva #(
  parameter int MEM_BITS = 1024
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                scl_i,
  input logic                sda_oe_i,
  input logic                busy_i,
  input logic                commit_i,
  input logic                wc_i,
  input logic [MEM_BITS-1:0] mem_i
);
  AST_SILENT_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !sda_oe_i);  // R6

  AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> busy_i);  // R3

  AST_WC_FREEZES_ARRAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wc_i) |-> $stable(mem_i));  // R7

  AST_ARRAY_ONLY_AT_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_i) |-> $past(commit_i));  // R5

  AST_DRIVE_ON_LOW_SCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> !scl_i);  // R12
endmodule

bind serial_eeprom_slave tws_sva #(.MEM_BITS(DEPTH * DATA_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_i(sda_oe_o),
  .busy_i(wr_busy), .commit_i(commit), .wc_i(wc_i), .mem_i(mem_flat)
);

// File: tb/sim_serial_eeprom_slave.sv
`timescale 1ns/1ps
module sim_serial_eeprom_slave;
  localparam int WCLK = 300;
  localparam int HP   = 5;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, wc = 1'b0;
  logic sda_oe, sda_line;
  assign sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;  // 50 MHz

  serial_eeprom_slave #(.WRITE_CLKS(WCLK)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(STRAP), .wc_i(wc), .sda_oe_o(sda_oe)
  );

  int tests = 0, fails = 0, glitches = 0, cycles = 0;
  logic [7:0] model [128];
  logic [6:0] cur = '0;
  logic prev_scl = 1'b1, prev_oe = 1'b0;

  always @(negedge clk) begin
    if (scl && prev_scl && sda_oe != prev_oe) glitches++;
    prev_scl <= scl;
    prev_oe  <= sda_oe;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      fails++; tests++;
      $display("FAIL watchdog act=%0d exp=<190000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    repeat (HP) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(); scl = 1'b1; tick(); sda_m = 1'b0; tick(); scl = 1'b0; tick();
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; tick(); scl = 1'b1; tick(); sda_m = 1'b1; tick();
  endtask
  task automatic put_bit(input logic b);
    sda_m = b; tick(); scl = 1'b1; tick(); scl = 1'b0; tick();
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(); scl = 1'b1; tick(); b = sda_line; scl = 1'b0; tick();
  endtask
  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(x);
    ack = ~x;
  endtask
  task automatic recv_byte(input bit mack, output logic [7:0] b);
    logic x;
    for (int i = 7; i >= 0; i--) begin get_bit(x); b[i] = x; end
    put_bit(~mack);
  endtask

  function automatic logic [7:0] dev(input logic rw);
    return {4'b1010, STRAP, rw};
  endfunction

  task automatic wait_cycle();
    repeat (WCLK + 20) @(negedge clk);
  endtask

  // write n bytes at a; models page wrap and write inhibit
  task automatic do_write(input logic [6:0] a, input logic [7:0] d [8], input int n,
                          input string req);
    bit ack;
    bus_start();
    send_byte(dev(1'b0), ack); chk(ack, req, ack, 1);
    send_byte({1'b0, a}, ack); chk(ack, req, ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ack);
      chk(ack, req, ack, 1);
    end
    bus_stop();
    for (int i = 0; i < n; i++)
      if (!wc) model[{a[6:2], 2'(a[1:0] + 2'(i))}] = d[i];
    cur = {a[6:2], 2'(a[1:0] + 2'(n))};
  endtask

  task automatic do_rand_read(input logic [6:0] a, input int n, input string req);
    bit ack;
    logic [7:0] b;
    bus_start();
    send_byte(dev(1'b0), ack); chk(ack, req, ack, 1);
    send_byte({1'b0, a}, ack); chk(ack, req, ack, 1);
    bus_start();
    send_byte(dev(1'b1), ack); chk(ack, req, ack, 1);
    cur = a;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk(b == model[cur], req, b, model[cur]);
      cur = cur + 7'd1;
    end
    bus_stop();
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    logic [7:0] d [8];
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: released line, zero array, counter at 0 (current-address read, R10)
    chk(sda_oe == 1'b0, "R1 oe", sda_oe, 0);
    bus_start();
    send_byte(dev(1'b1), ack); chk(ack, "R1", ack, 1);
    recv_byte(1'b0, b); chk(b == 8'h00, "R1 data", b, 0);
    bus_stop();
    cur = 7'd1;

    // R2: mismatched strap and device code get no acknowledge
    bus_start(); send_byte({4'b1010, ~STRAP, 1'b0}, ack); chk(!ack, "R2 strap", ack, 0);
    send_byte(8'h15, ack); chk(!ack, "R2 silent", ack, 0);
    bus_stop();
    bus_start(); send_byte({4'b1011, STRAP, 1'b1}, ack); chk(!ack, "R2 code", ack, 0); bus_stop();

    // R3 byte write, R6 busy window, R8 random read
    d[0] = 8'hA5;
    do_write(7'h15, d, 1, "R3");
    bus_start(); send_byte(dev(1'b0), ack); chk(!ack, "R6 busy nack", ack, 0); bus_stop();
    chk(sda_oe == 1'b0, "R6 released", sda_oe, 0);
    wait_cycle();
    do_rand_read(7'h15, 1, "R8 R3");

    // R4: six bytes into page 0x20 starting at 0x22 wrap within the page
    for (int i = 0; i < 6; i++) d[i] = 8'(8'h30 + i);
    do_write(7'h22, d, 6, "R4");
    wait_cycle();
    do_rand_read(7'h20, 4, "R4 readback");

    // R5: repeated start before stop discards buffered data
    bus_start();
    send_byte(dev(1'b0), ack); send_byte(8'h40, ack); send_byte(8'h77, ack);
    bus_start();
    send_byte(dev(1'b1), ack); chk(ack, "R5 rs", ack, 1);
    recv_byte(1'b0, b); chk(b == model[7'h41], "R5 cur", b, model[7'h41]);
    bus_stop();
    do_rand_read(7'h40, 2, "R5 unchanged");

    // R7: write control blocks commit, no busy window follows
    wc = 1'b1;
    d[0] = 8'h3C;
    do_write(7'h50, d, 1, "R7 acks");
    wc = 1'b0;
    do_rand_read(7'h50, 1, "R7 unchanged");

    // R9: rollover from 127 to 0
    for (int i = 0; i < 4; i++) d[i] = 8'(8'hC0 + i);
    do_write(7'h7C, d, 4, "R9 fill");
    wait_cycle();
    d[0] = 8'h99; d[1] = 8'h98;
    do_write(7'h00, d, 2, "R9 fill0");
    wait_cycle();
    do_rand_read(7'h7E, 4, "R9 wrap");

    // R10 current-address read continues; R11 NACK releases the line
    bus_start();
    send_byte(dev(1'b1), ack); chk(ack, "R10", ack, 1);
    recv_byte(1'b0, b); chk(b == model[cur], "R10 data", b, model[cur]);
    cur = cur + 7'd1;
    repeat (8) @(negedge clk);
    chk(sda_oe == 1'b0, "R11 released", sda_oe, 0);
    for (int i = 0; i < 3; i++) begin
      logic x;
      get_bit(x);
      chk(x == 1'b1, "R11 idle", x, 1);
    end
    bus_stop();

    // random page writes with occasional write inhibit (R4 R7 R8 R9)
    for (int it = 0; it < 25; it++) begin
      logic [6:0] a;
      int n;
      a  = 7'($urandom_range(0, 127));
      n  = $urandom_range(1, 6);
      wc = ($urandom_range(0, 3) == 0);
      for (int i = 0; i < 8; i++) d[i] = 8'($urandom);
      do_write(a, d, n, "R4 rnd");
      if (!wc) wait_cycle();
      wc = 1'b0;
      do_rand_read({a[6:2], 2'b00}, 4, "R8 rnd");
    end

    // R9: whole-array sequential read crossing the end
    do_rand_read(7'h60, 130, "R9 full");

    chk(glitches == 0, "R12 drive on low scl", glitches, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule